// File: doc/BRIEF.md
# Banked Memory Odd-Parity Guard

This block adds a ninth, odd-parity bit lane to a byte-wide memory built from several banks, each bank enabled by its own row-strobe line. While a byte is being written, the block presents the parity bit that the memory stores in the extra lane. While a byte is being read, it checks the byte and its stored bit together at the read-data-valid point.

When that check fails, the block records which bank strobe was active. It then shows the failing bank on a per-bank indicator vector and as a binary index, and it raises a halt request to the processor. The record is sticky. The first failure is kept, and later failures cannot replace it until the error-clear input is pulsed.

The number of banks is a parameter. Bank strobes are active high and at most one of them is active in a cycle.

Top module: `bank_parity_guard`

## Requirements
- R1: During a write, `parOut` is set so that the total count of ones across `wrData` and `parOut` is odd.
- R2: After reset, `errValid`, `haltReq`, `errBankOneHot` and `errBankIdx` are all zero.
- R3: A read whose byte and stored bit together hold an odd count of ones raises no error.
- R4: A read meets four conditions: `rdValid` is high, `wrEn` is low, a bank strobe is active, and the byte plus stored bit hold an even count of ones. If no error is held, `errValid` is set at the next clock edge and `errBankOneHot` takes the value of `bankSel`.
- R5: A parity mismatch while `rdValid` is low is ignored.
- R6: While `wrEn` is high, the parity lane is not checked, even if `rdValid` is high.
- R7: While an error is held, later failing reads change neither `errBankOneHot` nor `errBankIdx`.
- R8: `errClr` high at a clock edge clears the held error, the bank vector and the index. A failing read in that same cycle is dropped, because the clear takes priority.
- R9: `haltReq` is high exactly while an error is held, starting from the clock edge that captures the failure.
- R10: A failing read with no bank strobe active is ignored.
- R11: `errBankIdx` is the bit position of the held bank, with bank 0 at bit 0 of `bankSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bankSel | input | NUM_BANKS | Active-high row strobe per bank |
| wrEn | input | 1 | Write cycle in progress |
| wrData | input | DATA_W | Byte being written |
| parOut | output | 1 | Odd-parity bit to store in the ninth lane |
| rdValid | input | 1 | Read data valid: the check point |
| rdData | input | DATA_W | Byte read back |
| rdPar | input | 1 | Stored parity bit read back |
| errClr | input | 1 | Releases the held error |
| errValid | output | 1 | An error is held |
| errBankOneHot | output | NUM_BANKS | Indicator of the failing bank |
| errBankIdx | output | IDX_W | Binary index of the failing bank |
| haltReq | output | 1 | Sticky halt request to the processor |

## Verification
The properties assume that `bankSel` never has more than one strobe active. Under that assumption, a held error always names exactly one bank. The random stimulus picks either a single bank or no bank, so it never drives two strobes at once. It mixes writes, clean reads, corrupted reads, reads with `rdValid` low and reads overlapped with `wrEn`. Clear pulses arrive at random, sometimes in the same cycle as a failing read.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  // strobes from control to datapath for the error latch
  typedef struct packed {
    logic capture;
    logic clear;
  } latchCmd_t;
endpackage

// File: rtl/bpg_datapath.sv
module bpg_datapath
  import bpg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_BANKS-1:0] bankSel,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 rdValid,
  input  logic [DATA_W-1:0]    rdData,
  input  logic                 rdPar,
  input  latchCmd_t            cmd,
  output logic                 parOut,
  output logic                 parFail,
  output logic [NUM_BANKS-1:0] errBank,
  output logic [IDX_W-1:0]     errIdx
);
  logic [NUM_BANKS-1:0] bankQ;
  logic [IDX_W-1:0]     idxEnc;
  logic                 sumOdd;

  // odd parity: the stored bit makes the total count of ones odd
  assign parOut = ~(^wrData);

  assign sumOdd  = ^{rdData, rdPar};
  assign parFail = rdValid & ~wrEn & (|bankSel) & ~sumOdd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            bankQ <= '0;
    else if (cmd.clear)   bankQ <= '0;
    else if (cmd.capture) bankQ <= bankSel;
  end

  // lowest set bit wins
  always_comb begin
    idxEnc = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (bankQ[b]) idxEnc = IDX_W'(b);
    end
  end

  assign errBank = bankQ;
  assign errIdx  = idxEnc;
endmodule

// File: rtl/bpg_control.sv
module bpg_control
  import bpg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      parFail,
  input  logic      errClr,
  output latchCmd_t cmd,
  output logic      errValid
);
  logic heldQ;

  always_comb begin
    cmd.clear   = errClr;
    cmd.capture = parFail & ~heldQ & ~errClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            heldQ <= 1'b0;
    else if (cmd.clear)   heldQ <= 1'b0;
    else if (cmd.capture) heldQ <= 1'b1;
  end

  assign errValid = heldQ;
endmodule

// File: rtl/bank_parity_guard.sv
module bank_parity_guard
  import bpg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_BANKS-1:0] bankSel,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  output logic                 parOut,
  input  logic                 rdValid,
  input  logic [DATA_W-1:0]    rdData,
  input  logic                 rdPar,
  input  logic                 errClr,
  output logic                 errValid,
  output logic [NUM_BANKS-1:0] errBankOneHot,
  output logic [IDX_W-1:0]     errBankIdx,
  output logic                 haltReq
);
  latchCmd_t cmd;
  logic      parFail;
  logic      held;

  bpg_datapath #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .bankSel(bankSel), .wrEn(wrEn), .wrData(wrData),
    .rdValid(rdValid), .rdData(rdData), .rdPar(rdPar), .cmd(cmd),
    .parOut(parOut), .parFail(parFail), .errBank(errBankOneHot), .errIdx(errBankIdx)
  );

  bpg_control ctl_i (
    .clk(clk), .rstN(rstN), .parFail(parFail), .errClr(errClr),
    .cmd(cmd), .errValid(held)
  );

  assign errValid = held;
  assign haltReq  = held;
endmodule

// File: rtl/bank_parity_guard_chk.sv
module bank_parity_guard_chk #(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_BANKS-1:0] bankSel,
  input logic                 wrEn,
  input logic [DATA_W-1:0]    wrData,
  input logic                 parOut,
  input logic                 rdValid,
  input logic [DATA_W-1:0]    rdData,
  input logic                 rdPar,
  input logic                 errClr,
  input logic                 errValid,
  input logic [NUM_BANKS-1:0] errBankOneHot,
  input logic [IDX_W-1:0]     errBankIdx,
  input logic                 haltReq
);
  // input assumption: at most one strobe (R4)
  p_sel_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankSel));

  p_write_odd_r1: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (^{wrData, parOut}) == 1'b1);

  p_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !wrEn && (|bankSel) && !errValid && !errClr && !(^{rdData, rdPar}))
    |=> (errValid && errBankOneHot == $past(bankSel)));

  p_held_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> $countones(errBankOneHot) == 1);

  p_good_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!errValid && !(rdValid && (^{rdData, rdPar}) == 1'b0)) |=> !errValid);

  p_write_skip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!errValid && wrEn) |=> !errValid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && !errClr) |=> ($stable(errBankOneHot) && $stable(errBankIdx) && errValid));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    errClr |=> (!errValid && errBankOneHot == '0));

  p_halt_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltReq) |-> $past(rdValid && !wrEn && (|bankSel)));
endmodule

bind bank_parity_guard bank_parity_guard_chk #(
  .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .IDX_W(IDX_W)
) chk_i (.*);

// File: tb/bank_parity_guard_tb_top.sv
`timescale 1ns/1ps
module bank_parity_guard_tb_top;
  localparam int NB    = 4;
  localparam int DW    = 8;
  localparam int IW    = 2;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NB-1:0] bankSel = '0;
  logic          wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          parOut;
  logic          rdValid = 1'b0;
  logic [DW-1:0] rdData = '0;
  logic          rdPar = 1'b0;
  logic          errClr = 1'b0;
  logic          errValid;
  logic [NB-1:0] errBankOneHot;
  logic [IW-1:0] errBankIdx;
  logic          haltReq;

  int total = 0;
  int bad = 0;

  logic [DW:0]   mem [NB][DEPTH];
  logic          expValid = 1'b0;
  logic [NB-1:0] expBank = '0;

  always #2.5 clk = ~clk;

  bank_parity_guard #(.NUM_BANKS(NB), .DATA_W(DW)) dut_i (.*);

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] idxOf(input logic [NB-1:0] v);
    for (int b = 0; b < NB; b++) if (v[b]) return IW'(b);
    return '0;
  endfunction

  function automatic int bankNum(input logic [NB-1:0] v);
    for (int b = 0; b < NB; b++) if (v[b]) return b;
    return 0;
  endfunction

  task automatic checkOuts(input string req);
    chk({req, " valid"}, 32'(errValid), 32'(expValid));
    chk({req, " bank"},  32'(errBankOneHot), 32'(expBank));
    chk({req, " idx R11"}, 32'(errBankIdx), 32'(idxOf(expBank)));
    chk("R9 halt", 32'(haltReq), 32'(expValid));
  endtask

  // one clock: drive at negedge, edge in between, outputs settled at next negedge
  task automatic step(input logic wr, input logic rv, input logic [NB-1:0] sel,
                      input logic [3:0] addr, input logic [DW-1:0] wd,
                      input logic flip, input logic clr);
    logic [DW:0] word;
    logic fail;
    @(negedge clk);
    wrEn = wr; rdValid = rv; bankSel = sel; wrData = wd; errClr = clr;
    word = mem[bankNum(sel)][addr];
    rdData = word[DW-1:0];
    rdPar  = word[DW] ^ flip;
    #1;
    if (wr) begin
      chk("R1 parity odd", 32'(^{wrData, parOut}), 32'd1);
      if (sel != '0) mem[bankNum(sel)][addr] = {parOut, wd};
    end
    fail = rv && !wr && (sel != '0) && ((^{rdData, rdPar}) == 1'b0);
    if (clr) begin
      expValid = 1'b0; expBank = '0;
    end else if (fail && !expValid) begin
      expValid = 1'b1; expBank = sel;
    end
    @(negedge clk);
    wrEn = 1'b0; rdValid = 1'b0; errClr = 1'b0; bankSel = '0;
  endtask

  initial begin
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < DEPTH; a++) mem[b][a] = 9'h100;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    checkOuts("R2 reset");
    rstN = 1'b1;

    // fill each bank, one directed pattern per bank
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < DEPTH; a++)
        step(1'b1, 1'b0, NB'(1) << b, 4'(a), DW'(a * 37 + b), 1'b0, 1'b0);
    step(1'b1, 1'b0, 4'b0001, 4'd0, 8'h00, 1'b0, 1'b0);
    step(1'b1, 1'b0, 4'b0001, 4'd1, 8'hFF, 1'b0, 1'b0);

    step(1'b0, 1'b1, 4'b0001, 4'd0, '0, 1'b0, 1'b0);
    checkOuts("R3 clean read");
    step(1'b0, 1'b0, 4'b0010, 4'd3, '0, 1'b1, 1'b0);
    checkOuts("R5 no valid");
    step(1'b0, 1'b1, 4'b0000, 4'd3, '0, 1'b1, 1'b0);
    checkOuts("R10 no strobe");
    step(1'b1, 1'b1, 4'b0100, 4'd5, 8'h5A, 1'b1, 1'b0);
    checkOuts("R6 during write");
    step(1'b0, 1'b1, 4'b0100, 4'd2, '0, 1'b1, 1'b0);
    checkOuts("R4 capture");
    chk("R11 idx bank2", 32'(errBankIdx), 32'd2);
    step(1'b0, 1'b1, 4'b0010, 4'd2, '0, 1'b1, 1'b0);
    checkOuts("R7 hold");
    chk("R7 still bank2", 32'(errBankOneHot), 32'h4);
    step(1'b0, 1'b1, 4'b1000, 4'd2, '0, 1'b1, 1'b1);
    checkOuts("R8 clear priority");
    chk("R8 cleared", 32'(errValid), 32'd0);
    step(1'b0, 1'b1, 4'b1000, 4'd4, '0, 1'b1, 1'b0);
    checkOuts("R4 bank3");
    chk("R11 idx bank3", 32'(errBankIdx), 32'd3);
    step(1'b0, 1'b0, 4'b0000, 4'd0, '0, 1'b0, 1'b1);
    checkOuts("R8 clear");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      logic [NB-1:0] sel = ($urandom_range(0, 5) == 0) ? '0 : (NB'(1) << $urandom_range(0, NB - 1));
      logic flip = ($urandom_range(0, 5) == 0);
      logic clr = ($urandom_range(0, 9) == 0);
      logic wr = (op < 3);
      logic rv = (op != 7) && !wr ? 1'b1 : ($urandom_range(0, 3) == 0);
      step(wr, rv, sel, 4'($urandom_range(0, DEPTH - 1)), 8'($urandom), flip, clr);
      checkOuts("R4 R7 R8 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule